// File: doc/BRIEF.md
# Interrupt Routing Extension Configuration Registers

This block holds the control words for an optional virtualization extension of an external interrupt router. It sits on a 32-bit memory-mapped register bus inside a 4 KiB window. The window holds two registers. The first is a read-only capability word that lists which extension features exist. The second is a read/write mode word whose bits drive the routing logic: a global routing enable, an interrupt-number encoding mode and a CPU-number encoding mode.

Software must choose the modes while routing is disabled. A mode word write is stored only after it is masked with the capability word. Once routing is enabled, any nonzero write is refused with a bus error; a zero write is still accepted, so software can turn routing off and reconfigure.

The parameter `EXT_PRESENT` builds the block with or without the extension. Without it, the capability word is zero, every access to the window is refused, and routing comes out of reset already enabled.

Top module: `ext_cfg_regs`

## Requirements
- R1: With the extension present, a read of offset 0x000 returns 0x0000000F. The capability bits are: bit 0 extension present, bit 1 enable option, bit 2 interrupt encoding, bit 3 CPU encoding.
- R2: A write to offset 0x000 responds with an error and leaves the capability word unchanged.
- R3: An accepted write to offset 0x004 stores the write data ANDed with the capability word. A read of 0x004 returns the stored value. Outputs `route_enable`, `irq_encode_en` and `cpu_encode_en` follow stored bits 1, 2 and 3.
- R4: While stored bit 1 is set, a nonzero write to 0x004 responds with an error and is discarded. A zero write is accepted and clears the word.
- R5: With the extension present, reset clears the mode word, so all three mode outputs are 0.
- R6: A read of any other word offset in the window returns 0 without error. A write to such an offset has no effect and no error.
- R7: `req_size` gives log2 of the access bytes. Codes 0 and 1 (narrower than 4 bytes) and any address with bits [1:0] nonzero respond with an error, return read data 0, and have no effect. Codes 2 (4 bytes) and 3 (8 bytes, low word handled) are accepted.
- R8: Every cycle with `req_valid` high is answered by `rsp_ack` high in the next cycle. `rsp_err` is only ever high together with `rsp_ack`.
- R9: With the extension absent, every access responds with an error and read data 0. After reset, `route_enable` is 1 and the two encoding outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_size | input | 2 | log2 of the access size in bytes |
| req_wdata | input | DATA_W | Write data (low word) |
| rsp_ack | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Access refused; valid with rsp_ack |
| rsp_rdata | output | DATA_W | Read data; valid with rsp_ack |
| route_enable | output | 1 | Global routing enable (mode bit 1) |
| irq_encode_en | output | 1 | Interrupt encoding mode (mode bit 2) |
| cpu_encode_en | output | 1 | CPU encoding mode (mode bit 3) |

## Verification
A wrong mode word shows up on the three mode outputs in the cycle after the write that caused it. It also appears in the data of the next read of 0x004, so every stimulus vector reads the outputs back after its response. A broken lock either drops a legal zero write or lets a locked write through. Either fault gives a wrong `rsp_err` in the response cycle and a wrong output one cycle later. A decode fault in the absent build shows on the first access after reset, as a missing error or nonzero data.

// File: rtl/ext_cfg_pkg.sv
package ext_cfg_pkg;
    // capability word bit positions
    localparam int CAP_PRESENT_BIT = 0;
    localparam int CAP_ENOPT_BIT   = 1;
    localparam int CAP_IRQENC_BIT  = 2;
    localparam int CAP_CPUENC_BIT  = 3;
    // mode word bit positions
    localparam int MODE_EN_BIT     = 1;
    localparam int MODE_IRQENC_BIT = 2;
    localparam int MODE_CPUENC_BIT = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CAP  = 2'd1,
        SEL_MODE = 2'd2
    } sel_e;
endpackage

// File: rtl/ext_cfg_decode.sv
module ext_cfg_decode
    import ext_cfg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int LSB_W       = 2,
    parameter int CAP_OFS     = 0,
    parameter int MODE_OFS    = 4,
    parameter bit EXT_PRESENT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output sel_e              sel,
    output logic              bad
);
    localparam logic [ADDR_W-1:0] CAP_A  = ADDR_W'(CAP_OFS);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);

    always_comb begin
        if (addr == CAP_A)       sel = SEL_CAP;
        else if (addr == MODE_A) sel = SEL_MODE;
        else                     sel = SEL_NONE;
        bad = !EXT_PRESENT
           || (size < 2'(LSB_W))
           || (addr[LSB_W-1:0] != '0);
    end
endmodule

// File: rtl/ext_cfg_cap.sv
module ext_cfg_cap #(
    parameter int DATA_W      = 32,
    parameter int CAP_W       = 4,
    parameter bit EXT_PRESENT = 1'b1
) (
    output logic [DATA_W-1:0] cap
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < CAP_W) begin : g_used
            assign cap[i] = EXT_PRESENT;
        end else begin : g_zero
            assign cap[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ext_cfg_mode.sv
module ext_cfg_mode
    import ext_cfg_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int CAP_W       = 4,
    parameter bit EXT_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cap,
    output logic [CAP_W-1:0]  mode,
    output logic              reject
);
    localparam logic [CAP_W-1:0] RST_MODE =
        EXT_PRESENT ? '0 : CAP_W'(1 << MODE_EN_BIT);

    logic [CAP_W-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        reject = wr_req && mode_q[MODE_EN_BIT] && (wdata != '0);
        if (wr_req && !reject) begin
            mode_d = wdata[CAP_W-1:0] & cap[CAP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= RST_MODE;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;
endmodule

// File: rtl/ext_cfg_regs.sv
module ext_cfg_regs
    import ext_cfg_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int CAP_W       = 4,
    parameter int CAP_OFS     = 0,
    parameter int MODE_OFS    = 4,
    parameter bit EXT_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_ack,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              route_enable,
    output logic              irq_encode_en,
    output logic              cpu_encode_en
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int LSB_W      = $clog2(WORD_BYTES);

    typedef struct packed {
        logic              ack;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    sel_e              sel;
    logic              bad;
    logic [DATA_W-1:0] cap;
    logic [CAP_W-1:0]  mode;
    logic              mode_wr;
    logic              mode_reject;
    rsp_t              rsp_d, rsp_q;

    ext_cfg_decode #(
        .ADDR_W(ADDR_W), .LSB_W(LSB_W), .CAP_OFS(CAP_OFS),
        .MODE_OFS(MODE_OFS), .EXT_PRESENT(EXT_PRESENT)
    ) u_dec (
        .addr(req_addr), .size(req_size), .sel(sel), .bad(bad)
    );

    ext_cfg_cap #(
        .DATA_W(DATA_W), .CAP_W(CAP_W), .EXT_PRESENT(EXT_PRESENT)
    ) u_cap (
        .cap(cap)
    );

    assign mode_wr = req_valid && req_write && !bad && (sel == SEL_MODE);

    ext_cfg_mode #(
        .DATA_W(DATA_W), .CAP_W(CAP_W), .EXT_PRESENT(EXT_PRESENT)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_req(mode_wr), .wdata(req_wdata),
        .cap(cap), .mode(mode), .reject(mode_reject)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.ack   = req_valid;
        if (req_valid) begin
            if (bad) begin
                rsp_d.err = 1'b1;
            end else if (req_write) begin
                rsp_d.err = (sel == SEL_CAP) || mode_reject;
            end else begin
                case (sel)
                    SEL_CAP:  rsp_d.rdata = cap;
                    SEL_MODE: rsp_d.rdata = DATA_W'(mode);
                    default:  rsp_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_ack       = rsp_q.ack;
    assign rsp_err       = rsp_q.err;
    assign rsp_rdata     = rsp_q.rdata;
    assign route_enable  = mode[MODE_EN_BIT];
    assign irq_encode_en = mode[MODE_IRQENC_BIT];
    assign cpu_encode_en = mode[MODE_CPUENC_BIT];
endmodule

// File: rtl/ext_cfg_regs_chk.sv
module ext_cfg_regs_chk #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int CAP_OFS     = 0,
    parameter int MODE_OFS    = 4,
    parameter bit EXT_PRESENT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_ack,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              route_enable,
    input logic              irq_encode_en,
    input logic              cpu_encode_en
);
    logic good_shape;
    assign good_shape = (req_size >= 2'd2) && (req_addr[1:0] == 2'b00);

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack); // R8
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack); // R8
    AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_ack); // R8
    AST_CAP_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(CAP_OFS))
        |=> rsp_err); // R2
    AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && good_shape && route_enable
         && req_addr == ADDR_W'(MODE_OFS) && req_wdata != '0)
        |=> rsp_err && $stable({cpu_encode_en, irq_encode_en, route_enable})); // R4
    AST_IDLE_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable({cpu_encode_en, irq_encode_en, route_enable})); // R3
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_rdata == '0); // R7
    AST_ABSENT_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXT_PRESENT && req_valid) |=> rsp_err); // R9
endmodule

bind ext_cfg_regs ext_cfg_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_OFS(CAP_OFS),
    .MODE_OFS(MODE_OFS), .EXT_PRESENT(EXT_PRESENT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .route_enable(route_enable), .irq_encode_en(irq_encode_en),
    .cpu_encode_en(cpu_encode_en)
);

// File: tb/ext_cfg_regs_test.sv
module ext_cfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        ack, err, en, ie, ce;
    logic [31:0] rdata;
    logic        n_ack, n_err, n_en, n_ie, n_ce;
    logic [31:0] n_rdata;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    ext_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_ack(ack), .rsp_err(err), .rsp_rdata(rdata),
        .route_enable(en), .irq_encode_en(ie), .cpu_encode_en(ce)
    );

    ext_cfg_regs #(.EXT_PRESENT(1'b0)) uut_absent (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_ack(n_ack), .rsp_err(n_err), .rsp_rdata(n_rdata),
        .route_enable(n_en), .irq_encode_en(n_ie), .cpu_encode_en(n_ce)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        err;
        logic [31:0] rdata;
        logic [2:0]  st;   // {cpu, irq, enable}
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b0, 12'h000, 2'd2, 32'h0,        1'b0, 32'hF, 3'b000}, // R1
        '{4'd2, 1'b1, 12'h000, 2'd2, 32'hFFFF,     1'b1, 32'h0, 3'b000}, // R2
        '{4'd2, 1'b0, 12'h000, 2'd2, 32'h0,        1'b0, 32'hF, 3'b000}, // R2
        '{4'd3, 1'b1, 12'h004, 2'd2, 32'hC,        1'b0, 32'h0, 3'b110}, // R3
        '{4'd3, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'hC, 3'b110}, // R3
        '{4'd3, 1'b1, 12'h004, 2'd2, 32'hFFFFFFF7, 1'b0, 32'h0, 3'b011}, // R3
        '{4'd3, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'h7, 3'b011}, // R3
        '{4'd4, 1'b1, 12'h004, 2'd2, 32'h8,        1'b1, 32'h0, 3'b011}, // R4
        '{4'd4, 1'b1, 12'h004, 2'd2, 32'h100,      1'b1, 32'h0, 3'b011}, // R4
        '{4'd4, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'h7, 3'b011}, // R4
        '{4'd4, 1'b1, 12'h004, 2'd2, 32'h0,        1'b0, 32'h0, 3'b000}, // R4
        '{4'd4, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'h0, 3'b000}, // R4
        '{4'd3, 1'b1, 12'h004, 2'd2, 32'hA,        1'b0, 32'h0, 3'b101}, // R3
        '{4'd6, 1'b0, 12'h010, 2'd2, 32'h0,        1'b0, 32'h0, 3'b101}, // R6
        '{4'd6, 1'b1, 12'h100, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h0, 3'b101}, // R6
        '{4'd6, 1'b0, 12'hFFC, 2'd2, 32'h0,        1'b0, 32'h0, 3'b101}, // R6
        '{4'd6, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'hA, 3'b101}, // R6
        '{4'd7, 1'b0, 12'h000, 2'd1, 32'h0,        1'b1, 32'h0, 3'b101}, // R7
        '{4'd7, 1'b1, 12'h004, 2'd0, 32'h0,        1'b1, 32'h0, 3'b101}, // R7
        '{4'd7, 1'b0, 12'h002, 2'd2, 32'h0,        1'b1, 32'h0, 3'b101}, // R7
        '{4'd7, 1'b0, 12'h004, 2'd3, 32'h0,        1'b0, 32'hA, 3'b101}, // R7
        '{4'd7, 1'b1, 12'h006, 2'd2, 32'h0,        1'b1, 32'h0, 3'b101}, // R7
        '{4'd7, 1'b1, 12'h004, 2'd3, 32'h0,        1'b0, 32'h0, 3'b000}, // R7
        '{4'd7, 1'b0, 12'h004, 2'd2, 32'h0,        1'b0, 32'h0, 3'b000}  // R7
    };

    task automatic chk(input int r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    // one request cycle; leaves the bench at the negedge of the response cycle
    task automatic access(input logic wr, input logic [11:0] a,
                          input logic [1:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state of the present build
        chk(5, "reset ack", 32'(ack), 32'd0);
        chk(5, "reset modes", 32'({ce, ie, en}), 32'd0);
        // R9 reset state of the absent build
        chk(9, "absent reset modes", 32'({n_ce, n_ie, n_en}), 32'b001);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
            chk(int'(VECS[i].req), $sformatf("vec%0d ack", i), 32'(ack), 32'd1);
            chk(int'(VECS[i].req), $sformatf("vec%0d err", i), 32'(err), 32'(VECS[i].err));
            chk(int'(VECS[i].req), $sformatf("vec%0d rdata", i), rdata, VECS[i].rdata);
            chk(int'(VECS[i].req), $sformatf("vec%0d modes", i),
                32'({ce, ie, en}), 32'(VECS[i].st));
            // R9 absent build refuses everything
            chk(9, $sformatf("vec%0d absent err", i), 32'(n_err), 32'd1);
            chk(9, $sformatf("vec%0d absent rdata", i), n_rdata, 32'd0);
            chk(9, $sformatf("vec%0d absent modes", i),
                32'({n_ce, n_ie, n_en}), 32'b001);
        end

        // R8 back-to-back requests each get an ack; idle gives none
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h000; req_size = 2'd2;
        @(negedge clk);
        chk(8, "b2b first ack", 32'(ack), 32'd1);
        chk(8, "b2b first data", rdata, 32'hF);
        req_addr = 12'h004;
        @(negedge clk);
        req_valid = 1'b0;
        chk(8, "b2b second ack", 32'(ack), 32'd1);
        chk(8, "b2b second data", rdata, 32'h0);
        @(negedge clk);
        chk(8, "idle no ack", 32'(ack), 32'd0);
        chk(8, "idle no err", 32'(err), 32'd0);

        // R5 reset in mid-run clears a set mode word
        access(1'b1, 12'h004, 2'd2, 32'hE);
        chk(3, "pre-reset modes", 32'({ce, ie, en}), 32'b111);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(5, "mid reset modes", 32'({ce, ie, en}), 32'd0);
        chk(9, "absent mid reset modes", 32'({n_ce, n_ie, n_en}), 32'b001);
        rst_n = 1'b1;
        access(1'b0, 12'h004, 2'd2, 32'h0);
        chk(5, "post reset readback", rdata, 32'h0);
        chk(5, "post reset err", 32'(err), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule